// File: doc/BRIEF.md
# Digital Angle Tracking Loop

This block turns a stream of demodulated resolver samples into a shaft angle and a shaft speed. Each accepted sample pair (a signed sin θ and a signed cos θ) is compared with the block's own angle estimate φ through a sine/cosine table. The result is an error proportional to sin(θ − φ). That error feeds two cascaded integrators: a saturating velocity integrator, and a wide position accumulator that also takes a proportional share of the error. The 12-bit output angle follows the top bits of the position accumulator at exactly one LSB per accepted sample.

Because there are two integrators in series, a constant shaft speed is followed with no steady-state angle error. The velocity integrator is clamped so that the accumulator advances by less than one angle LSB per sample, which is also the speed limit of the block. The output angle takes a one-LSB step on every sample, even when it is already on target. The error therefore never sits still, and the loop cannot rest at the unstable balance point half a turn away from the shaft.

Top module: `angle_track_loop`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, angle_o, vel_o and err_o are zero. All loop state returns to zero as well.
- R2: On each accepted sample, err_o becomes sin_i·C − cos_i·S, where S and C are the table sine and cosine of the angle held before that sample. Table entry k (k = 0..1023) is 2047·16·p / (5·4096² − 4·p), truncated, with u = 2k+1 and p = u·(4096 − u). Angle bits [11:10] pick the quadrant and bits [9:0] give k. With a = entry[k] and b = entry[1023−k], the (S, C) pairs for quadrants 0, 1, 2 and 3 are (a, b), (b, −a), (−a, −b) and (−b, a).
- R3: The 24-bit velocity integrator adds each new error and is clamped to ±(2^23 − 1). vel_o is its upper 12 bits, which is the integrator arithmetically shifted right by 12.
- R4: The 35-bit position accumulator wraps modulo 2^35. On each sample it adds the new integrator value plus 64 times the error, with that sum clamped to ±(2^23 − 1). Its top 12 bits are the target angle.
- R5: Every accepted sample changes angle_o by exactly +1 or −1 modulo 4096. The step goes toward the target along the shorter way (a signed 12-bit difference that is negative means step down). When the output is already on target, it steps up if the new error is ≥ 0 and down otherwise.
- R6: A cycle with smp_vld_i low leaves angle_o, vel_o and err_o unchanged, whatever sin_i and cos_i carry.
- R7: For a static input and for a constant-speed input of either sign, the loop settles to within 4 LSB of θ. vel_o then settles within 8 counts of speed × 2048, with the speed measured in angle LSB per sample.
- R8: The angle wraps continuously across 4095 ↔ 0 while tracking.
- R9: An input faster than one LSB per sample drives vel_o to its full-scale value of 2047 and no further.
- R10: Started at φ = 0 with θ at exactly half a turn, the loop leaves the false null and settles on θ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample pair on sin_i and cos_i is accepted this cycle |
| sin_i | input | SMP_W | Signed demodulated sin θ sample |
| cos_i | input | SMP_W | Signed demodulated cos θ sample |
| angle_o | output | ANG_W | Unsigned angle φ, one turn = 2^ANG_W |
| vel_o | output | VEL_W | Two's complement speed, top bits of the velocity integrator |
| err_o | output | 2*SMP_W+1 | Signed error term from the last accepted sample |

## Verification
The loop is driven with a static angle reached from reset, a start exactly half a turn away, a slow positive ramp with gaps in the sample strobe, a faster negative ramp, and an over-speed ramp. The static angle separates the proportional and integral paths, because only a correct pair settles without offset. The two ramps confirm that speed is held with zero lag in both directions and across the wrap. The half-turn start shows that the forced one-LSB motion breaks the false null. The over-speed run exposes the velocity clamp, and an exact integer model compared every cycle pins down table folding, rounding, clamping and step direction.

// File: rtl/atl_pkg.sv
`timescale 1ns/1ps
package atl_pkg;

    // Quarter-wave sine entry at the centre of bin idx, rational approximation.
    function automatic longint quarter_sine(input int idx, input int lut_bits, input int amp);
        longint h;
        longint u;
        longint p;
        h = longint'(4) <<< lut_bits;
        u = 2 * longint'(idx) + 1;
        p = u * (h - u);
        return (longint'(amp) * 16 * p) / (5 * h * h - 4 * p);
    endfunction

endpackage

// File: rtl/atl_sincos.sv
`timescale 1ns/1ps
module atl_sincos #(
    parameter int ANG_W    = 12,
    parameter int LUT_BITS = 10,
    parameter int AMP_W    = 12
) (
    input  logic [ANG_W-1:0]        ang_i,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);
    localparam int N   = 1 << LUT_BITS;
    localparam int AMP = (1 << (AMP_W - 1)) - 1;

    logic signed [AMP_W-1:0] rom [N];

    for (genvar g = 0; g < N; g++) begin : g_rom
        assign rom[g] = $signed(AMP_W'(atl_pkg::quarter_sine(g, LUT_BITS, AMP)));
    end

    logic [1:0]              quad;
    logic [LUT_BITS-1:0]     idx;
    logic signed [AMP_W-1:0] a_val;
    logic signed [AMP_W-1:0] b_val;

    assign quad  = ang_i[ANG_W-1 -: 2];
    assign idx   = ang_i[ANG_W-3 -: LUT_BITS];
    assign a_val = rom[idx];
    assign b_val = rom[~idx];

    always_comb begin
        unique case (quad)
            2'd0:    begin sin_o = a_val;  cos_o = b_val;  end
            2'd1:    begin sin_o = b_val;  cos_o = -a_val; end
            2'd2:    begin sin_o = -a_val; cos_o = -b_val; end
            default: begin sin_o = -b_val; cos_o = a_val;  end
        endcase
    end
endmodule

// File: rtl/atl_phase_det.sv
`timescale 1ns/1ps
module atl_phase_det #(
    parameter int SMP_W = 12
) (
    input  logic signed [SMP_W-1:0] s_i,
    input  logic signed [SMP_W-1:0] c_i,
    input  logic signed [SMP_W-1:0] sphi_i,
    input  logic signed [SMP_W-1:0] cphi_i,
    output logic signed [2*SMP_W:0] err_o
);
    logic signed [2*SMP_W-1:0] prod_a;
    logic signed [2*SMP_W-1:0] prod_b;

    assign prod_a = s_i * cphi_i;
    assign prod_b = c_i * sphi_i;
    assign err_o  = $signed({prod_a[2*SMP_W-1], prod_a}) - $signed({prod_b[2*SMP_W-1], prod_b});
endmodule

// File: rtl/angle_track_loop.sv
`timescale 1ns/1ps
module angle_track_loop #(
    parameter int ANG_W    = 12,
    parameter int SMP_W    = 12,
    parameter int VEL_W    = 12,
    parameter int VINT_W   = 24,
    parameter int LUT_BITS = 10,
    parameter int KP_SH    = 6,
    parameter int KI_SH    = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld_i,
    input  logic signed [SMP_W-1:0] sin_i,
    input  logic signed [SMP_W-1:0] cos_i,
    output logic [ANG_W-1:0]        angle_o,
    output logic signed [VEL_W-1:0] vel_o,
    output logic signed [2*SMP_W:0] err_o
);
    localparam int ERR_W  = 2 * SMP_W + 1;
    localparam int POS_W  = ANG_W + VINT_W - 1;
    localparam int WIDE_W = ERR_W + VINT_W + KP_SH + KI_SH + 2;
    localparam logic signed [WIDE_W-1:0] VMAX =
        {{(WIDE_W - VINT_W + 1){1'b0}}, {(VINT_W - 1){1'b1}}};
    localparam logic signed [WIDE_W-1:0] VMIN = -VMAX;

    typedef struct packed {
        logic [ANG_W-1:0]         ang;
        logic [POS_W-1:0]         pos;
        logic signed [VINT_W-1:0] vint;
        logic signed [ERR_W-1:0]  err;
    } state_t;

    state_t st_q, st_d;

    logic signed [SMP_W-1:0]  sphi, cphi;
    logic signed [ERR_W-1:0]  pd_err;
    logic signed [WIDE_W-1:0] e_w, vint_w, vnew_w, inc_w;
    logic [POS_W-1:0]         pos_next;
    logic [ANG_W-1:0]         target, diff;
    logic                     step_up;
    logic [ANG_W-1:0]         pos_top_q;
    logic signed [VINT_W-1:0] vint_q;

    atl_sincos #(.ANG_W(ANG_W), .LUT_BITS(LUT_BITS), .AMP_W(SMP_W)) u_sincos (
        .ang_i (st_q.ang),
        .sin_o (sphi),
        .cos_o (cphi)
    );

    atl_phase_det #(.SMP_W(SMP_W)) u_pd (
        .s_i    (sin_i),
        .c_i    (cos_i),
        .sphi_i (sphi),
        .cphi_i (cphi),
        .err_o  (pd_err)
    );

    function automatic logic signed [WIDE_W-1:0] clamp_v(input logic signed [WIDE_W-1:0] x);
        if (x > VMAX) return VMAX;
        if (x < VMIN) return VMIN;
        return x;
    endfunction

    always_comb begin
        st_d     = st_q;
        e_w      = {{(WIDE_W - ERR_W){pd_err[ERR_W-1]}}, pd_err};
        vint_w   = {{(WIDE_W - VINT_W){st_q.vint[VINT_W-1]}}, st_q.vint};
        vnew_w   = clamp_v(vint_w + (e_w <<< KI_SH));
        inc_w    = clamp_v(vnew_w + (e_w <<< KP_SH));
        pos_next = st_q.pos + inc_w[POS_W-1:0];
        target   = pos_next[POS_W-1 -: ANG_W];
        diff     = target - st_q.ang;
        if (diff == '0) begin
            step_up = ~pd_err[ERR_W-1];
        end else begin
            step_up = ~diff[ANG_W-1];
        end
        if (smp_vld_i) begin
            st_d.err  = pd_err;
            st_d.vint = vnew_w[VINT_W-1:0];
            st_d.pos  = pos_next;
            st_d.ang  = step_up ? st_q.ang + ANG_W'(1) : st_q.ang - ANG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic unused_hi;
    assign unused_hi = ^{vnew_w[WIDE_W-1:VINT_W], inc_w[WIDE_W-1:POS_W]};

    assign pos_top_q = st_q.pos[POS_W-1 -: ANG_W];
    assign vint_q    = st_q.vint;
    assign angle_o   = st_q.ang;
    assign vel_o     = vint_q[VINT_W-1 -: VEL_W];
    assign err_o     = st_q.err;
endmodule

// File: rtl/atl_checker.sv
`timescale 1ns/1ps
module atl_checker #(
    parameter int ANG_W  = 12,
    parameter int VINT_W = 24,
    parameter int ERR_W  = 25
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     vld,
    input logic [ANG_W-1:0]         ang,
    input logic [ANG_W-1:0]         pos_top,
    input logic signed [VINT_W-1:0] vint,
    input logic signed [ERR_W-1:0]  err
);
    localparam logic [VINT_W-1:0] VNEG = {1'b1, {(VINT_W - 1){1'b0}}};
    localparam logic [ANG_W-1:0]  ONE  = ANG_W'(1);

    logic [ANG_W-1:0] gap;
    assign gap = pos_top - ang;

    // R1: reset leaves every output and integrator at zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (ang == '0 && vint == '0 && err == '0));

    // R3: velocity integrator never reaches the most negative code
    a_r3_vint_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        vint != VNEG);

    // R5: each accepted sample moves the angle by one LSB
    a_r5_one_lsb_step: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> (ang == ANG_W'($past(ang) + ONE)) || (ang == ANG_W'($past(ang) - ONE)));

    // R5: output angle stays within one LSB of the accumulator target
    a_r5_follows_target: assert property (@(posedge clk) disable iff (!rst_n)
        (gap == '0) || (gap == ONE) || (gap == '1));

    // R6: idle cycles hold the state
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> ($stable(ang) && $stable(vint) && $stable(err)));
endmodule

bind angle_track_loop atl_checker #(
    .ANG_W  (ANG_W),
    .VINT_W (VINT_W),
    .ERR_W  (2 * SMP_W + 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (smp_vld_i),
    .ang     (angle_o),
    .pos_top (pos_top_q),
    .vint    (vint_q),
    .err     (err_o)
);

// File: tb/angle_track_loop_tb.sv
`timescale 1ns/1ps
module angle_track_loop_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               vld = 1'b0;
    logic signed [11:0] sin_s = '0;
    logic signed [11:0] cos_s = '0;
    logic [11:0]        angle_o;
    logic signed [11:0] vel_o;
    logic signed [24:0] err_o;

    angle_track_loop u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(vld), .sin_i(sin_s), .cos_i(cos_s),
        .angle_o(angle_o), .vel_o(vel_o), .err_o(err_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit wrapped = 1'b0;
    bit saw_full = 1'b0;
    longint m_ang = 0, m_pos = 0, m_v = 0, m_err = 0;
    real th = 0.0;
    localparam longint POS_MASK = (longint'(1) << 35) - 1;
    localparam longint VLIM = (longint'(1) << 23) - 1;
    localparam real TWO_PI = 6.283185307179586;

    task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic longint q_sine(input longint k);
        longint u, p, h;
        h = 4096;
        u = 2 * k + 1;
        p = u * (h - u);
        return (longint'(2047) * 16 * p) / (5 * h * h - 4 * p);
    endfunction

    function automatic longint clampv(input longint x);
        if (x > VLIM) return VLIM;
        if (x < -VLIM) return -VLIM;
        return x;
    endfunction

    task automatic step(input bit v, input int sv, input int cv);
        longint a, b, sp, cp, e, inc, tgt, dif;
        int p_ang, p_vel, p_err;
        bit up;
        vld = v; sin_s = 12'(sv); cos_s = 12'(cv);
        p_ang = int'(angle_o); p_vel = int'(vel_o); p_err = int'(err_o);
        @(posedge clk);
        if (v) begin
            a = q_sine(m_ang & 1023);
            b = q_sine(1023 - (m_ang & 1023));
            case (m_ang >> 10)
                0: begin sp = a;  cp = b;  end
                1: begin sp = b;  cp = -a; end
                2: begin sp = -a; cp = -b; end
                default: begin sp = -b; cp = a; end
            endcase
            e = longint'(sv) * cp - longint'(cv) * sp;
            m_v = clampv(m_v + e);
            inc = clampv(m_v + e * 64);
            m_pos = (m_pos + inc) & POS_MASK;
            tgt = m_pos >> 23;
            dif = (tgt - m_ang) & 4095;
            up = (dif == 0) ? (e >= 0) : (dif < 2048);
            m_ang = (m_ang + (up ? 1 : 4095)) & 4095;
            m_err = e;
        end
        @(negedge clk);
        chk($signed(err_o) == m_err, "R2 err", $signed(err_o), m_err);
        chk($signed(vel_o) == (m_v >>> 12), "R3 vel", $signed(vel_o), m_v >>> 12);
        chk(angle_o == m_ang, "R4 angle", angle_o, m_ang);
        if (v) begin
            chk(((int'(angle_o) - p_ang) & 4095) == 1 || ((int'(angle_o) - p_ang) & 4095) == 4095,
                "R5 step", angle_o, p_ang);
            if ((p_ang == 4095 && angle_o == 0) || (p_ang == 0 && angle_o == 4095)) wrapped = 1'b1;
        end else begin
            chk(int'(angle_o) == p_ang && int'(vel_o) == p_vel && int'(err_o) == p_err,
                "R6 hold", angle_o, p_ang);
        end
        if (vel_o == 12'sd2047) saw_full = 1'b1;
    endtask

    task automatic drive_theta(input bit v);
        step(v, int'(2000.0 * $sin(TWO_PI * th / 4096.0)), int'(2000.0 * $cos(TWO_PI * th / 4096.0)));
    endtask

    function automatic int ang_dev();
        int d;
        d = int'(angle_o) - int'($floor(th + 0.5));
        d = ((d % 4096) + 4096) % 4096;
        if (d >= 2048) d -= 4096;
        return d;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; vld = 1'b0;
        m_ang = 0; m_pos = 0; m_v = 0; m_err = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(angle_o == 0 && vel_o == 0 && err_o == 0, "R1 reset", angle_o, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(angle_o == 0 && vel_o == 0 && err_o == 0, "R1 after release", angle_o, 0);
    endtask

    task automatic advance(input real rate, input int n, input int gap_every);
        for (int i = 0; i < n; i++) begin
            if (gap_every > 0 && (i % gap_every) == 0) begin
                drive_theta(1'b0);
            end else begin
                th = th + rate;
                if (th >= 4096.0) th = th - 4096.0;
                if (th < 0.0) th = th + 4096.0;
                drive_theta(1'b1);
            end
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R6: inputs change while strobe is low
        sin_s = 12'sd1500; cos_s = -12'sd900;
        for (int i = 0; i < 5; i++) step(1'b0, 1500 - i * 200, -900 + i * 100);
        // R7: static angle reached from zero
        th = 1000.0;
        advance(0.0, 6000, 0);
        chk(ang_dev() <= 4 && ang_dev() >= -4, "R7 static angle", angle_o, 1000);
        chk(vel_o <= 8 && vel_o >= -8, "R7 static speed", vel_o, 0);
        // R1: reset from a busy state
        do_reset();
        // R10: start exactly half a turn away
        th = 2048.0;
        advance(0.0, 6000, 0);
        chk(ang_dev() <= 4 && ang_dev() >= -4, "R10 false null left", angle_o, 2048);
        // R7/R8: positive ramp with strobe gaps, crossing the wrap
        wrapped = 1'b0;
        advance(0.125, 24000, 6);
        chk(ang_dev() <= 4 && ang_dev() >= -4, "R7 positive ramp angle", angle_o, longint'(th));
        chk(vel_o >= 248 && vel_o <= 264, "R7 positive ramp speed", vel_o, 256);
        chk(wrapped, "R8 wrap seen", wrapped, 1);
        // R7: negative ramp
        advance(-0.25, 8000, 0);
        chk(ang_dev() <= 4 && ang_dev() >= -4, "R7 negative ramp angle", angle_o, longint'(th));
        chk(vel_o >= -520 && vel_o <= -504, "R7 negative ramp speed", vel_o, -512);
        // R9: over-speed
        saw_full = 1'b0;
        advance(1.5, 3000, 0);
        chk(saw_full, "R9 full scale speed", saw_full, 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule